// File: doc/BRIEF.md
# Computed-Read Special Register File

This block is a 64-entry register space, 16 bits wide, with one write port and one combinational read port. Most addresses are plain storage. A group of high addresses does not return what is stored: it returns a function of stored words. The functions are a two-way mask, a conditional pick between two words, single-bit rotations in both directions, a bitwise inverse and a ones'-complement sum with end-around carry. A core that can only copy one register to another can therefore do arithmetic and logic: it writes the operands and then reads the result address.

Address 0 reads as zero. A write to it is not stored; it is sent out on a registered display strobe. Address 63 is the program counter. Its value is always visible on a side port. A side input advances it by one. A write to address 63 loads it and raises a one-cycle branch pulse. Instruction fetch and sequencing stay in the core.

Top module: `calc_regfile`

## Requirements
- R1: After synchronous active-low reset, every stored word and the program counter are zero. All reads return zero except address 62, which returns 0xFFFF. `disp_valid` and `branch_taken` are low.
- R2: Reading address 0 returns zero. A write to address 0 drives `disp_valid` high with `disp_data` equal to the written word for exactly the cycle after the write edge. Nothing is stored. A cycle with no such write leaves `disp_valid` low.
- R3: Addresses 1 to 52 and 60 read back the last written word. A write takes effect at the clock edge, so a read of the same address in the write cycle returns the old word.
- R4: Reading 53 returns stored54 AND NOT stored53. Reading 54 returns stored53 AND NOT stored54.
- R5: Addresses 55 and 57 read as zero, but they still store written words (observable through R6).
- R6: Reading 56 returns stored55 when stored56 is non-zero, and stored57 when stored56 is zero.
- R7: Reading 58 returns its stored word rotated right by one bit (bit 0 moves to bit 15). Reading 59 returns its stored word rotated left by one bit (bit 15 moves to bit 0).
- R8: Reading 61 returns stored60 + stored61 mod 2^16, plus 1 when that sum carries out of bit 15 (for example 0xFFFF+0x0001 gives 0x0001, and 0x8000+0x8000 gives 0x0001).
- R9: Reading 62 returns the bitwise inverse of its stored word.
- R10: Reading 63 returns `pc_value`. When `pc_step` is high, the counter advances by one at the edge, wrapping 0xFFFF to 0. A write to 63 loads the written word at the edge and raises `branch_taken` for the following cycle. A branch write in the same cycle as `pc_step` wins. With neither, the counter holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 6 | Write address |
| wr_data | input | 16 | Write word |
| rd_addr | input | 6 | Read address |
| rd_data | output | 16 | Read result, stored or computed |
| pc_step | input | 1 | Advance the program counter by one |
| pc_value | output | 16 | Current program counter |
| branch_taken | output | 1 | Pulse after a write to address 63 |
| disp_valid | output | 1 | Pulse after a write to address 0 |
| disp_data | output | 16 | Word written to address 0 |

## Verification
Two functions can land in the same cycle: a program counter step and a branch write to address 63, and a write and a read of the same address. The bench asserts `pc_step` in the cycle that writes address 63, then checks that the loaded word wins and the pulse appears. It also reads an address in the cycle that writes it, checks for the old word before the edge and the new word after it. The computed reads are swept over every address for several operand patterns. Each result is compared with a value the bench works out from its own copy of what was written.

// File: rtl/crf_pkg.sv
// Package for the computed-read register file.
// Holds the address map constants whose positions set the read behaviour.
// Assumes a fixed 6-bit address space of 64 entries.
package crf_pkg;
    localparam int ADDR_W   = 6;
    localparam int NUM_REGS = 1 << ADDR_W;

    typedef logic [ADDR_W-1:0] crf_addr_t;

    localparam crf_addr_t A_DISPLAY = 6'd0;
    localparam crf_addr_t A_MASK_X  = 6'd53;
    localparam crf_addr_t A_MASK_Y  = 6'd54;
    localparam crf_addr_t A_PICK_T  = 6'd55;
    localparam crf_addr_t A_PICK_C  = 6'd56;
    localparam crf_addr_t A_PICK_F  = 6'd57;
    localparam crf_addr_t A_ROT_R   = 6'd58;
    localparam crf_addr_t A_ROT_L   = 6'd59;
    localparam crf_addr_t A_SUM_X   = 6'd60;
    localparam crf_addr_t A_SUM_Y   = 6'd61;
    localparam crf_addr_t A_INVERT  = 6'd62;
    localparam crf_addr_t A_PC      = 6'd63;
endpackage

// File: rtl/crf_store.sv
// Storage cells for addresses 1..NUM_REGS-2.
// Address 0 (display) and the top address (PC) hold no cell here and read as zero.
// Assumes one write per cycle; a write lands at the clock edge.
module crf_store
    import crf_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  crf_addr_t         wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] regs_q [NUM_REGS]
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (i == 0 || i == NUM_REGS - 1) begin : g_none
            assign regs_q[i] = '0;
        end else begin : g_cell
            logic [DATA_W-1:0] cell_q;
            // Hold one word, cleared on reset, loaded when addressed.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cell_q <= '0;
                else if (wr_en && wr_addr == crf_addr_t'(i))
                    cell_q <= wr_data;
            end
            assign regs_q[i] = cell_q;
        end
    end
endmodule

// File: rtl/crf_pc.sv
// Program counter held at the top address.
// A load (branch write) takes priority over a single step. It wraps at 2^DATA_W.
// branch_q pulses for one cycle after a load.
module crf_pc #(
    parameter int              DATA_W   = 16,
    parameter logic [DATA_W-1:0] PC_RESET = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_val,
    input  logic              step,
    output logic [DATA_W-1:0] pc_q,
    output logic              branch_q
);
    // Update the counter: load beats step, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= PC_RESET;
            branch_q <= 1'b0;
        end else begin
            branch_q <= load_en;
            if (load_en)
                pc_q <= load_val;
            else if (step)
                pc_q <= pc_q + DATA_W'(1);
        end
    end
endmodule

// File: rtl/crf_readmux.sv
// Combinational read path: returns stored words or computed functions by address.
// Assumes regs entries 0 and NUM_REGS-1 are zero; the PC arrives separately.
module crf_readmux
    import crf_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] regs [NUM_REGS],
    input  logic [DATA_W-1:0] pc,
    input  crf_addr_t         rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W:0]   raw_sum;
    logic [DATA_W-1:0] oc_sum;

    // Ones'-complement sum: fold the carry-out back into bit 0.
    always_comb begin
        raw_sum = {1'b0, regs[A_SUM_X]} + {1'b0, regs[A_SUM_Y]};
        oc_sum  = raw_sum[DATA_W-1:0] + {{(DATA_W-1){1'b0}}, raw_sum[DATA_W]};
    end

    // Pick the read result for the requested address.
    always_comb begin
        case (rd_addr)
            A_DISPLAY: rd_data = '0;
            A_MASK_X:  rd_data = regs[A_MASK_Y] & ~regs[A_MASK_X];
            A_MASK_Y:  rd_data = regs[A_MASK_X] & ~regs[A_MASK_Y];
            A_PICK_T:  rd_data = '0;
            A_PICK_C:  rd_data = (|regs[A_PICK_C]) ? regs[A_PICK_T] : regs[A_PICK_F];
            A_PICK_F:  rd_data = '0;
            A_ROT_R:   rd_data = {regs[A_ROT_R][0], regs[A_ROT_R][DATA_W-1:1]};
            A_ROT_L:   rd_data = {regs[A_ROT_L][DATA_W-2:0], regs[A_ROT_L][DATA_W-1]};
            A_SUM_Y:   rd_data = oc_sum;
            A_INVERT:  rd_data = ~regs[A_INVERT];
            A_PC:      rd_data = pc;
            default:   rd_data = regs[rd_addr];
        endcase
    end
endmodule

// File: rtl/calc_regfile.sv
// Top of the computed-read register file.
// Routes the write port to storage, the program counter or the display strobe,
// and exposes the combinational read path. Synchronous active-low reset.
module calc_regfile
    import crf_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [5:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [5:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              pc_step,
    output logic [DATA_W-1:0] pc_value,
    output logic              branch_taken,
    output logic              disp_valid,
    output logic [DATA_W-1:0] disp_data
);
    logic [DATA_W-1:0] regs_q [NUM_REGS];
    logic              pc_load;
    logic              disp_hit;

    assign pc_load  = wr_en && (wr_addr == A_PC);
    assign disp_hit = wr_en && (wr_addr == A_DISPLAY);

    crf_store #(.DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .regs_q  (regs_q)
    );

    crf_pc #(.DATA_W(DATA_W), .PC_RESET('0)) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (pc_load),
        .load_val (wr_data),
        .step     (pc_step),
        .pc_q     (pc_value),
        .branch_q (branch_taken)
    );

    crf_readmux #(.DATA_W(DATA_W)) u_rmux (
        .regs    (regs_q),
        .pc      (pc_value),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // Register the display strobe and the word written to address 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_valid <= 1'b0;
            disp_data  <= '0;
        end else begin
            disp_valid <= disp_hit;
            if (disp_hit)
                disp_data <= wr_data;
        end
    end
endmodule

// File: rtl/crf_checker.sv
// Property checker for calc_regfile, attached by bind.
// Observes only top-level ports.
module crf_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [5:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [5:0]        rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              pc_step,
    input logic [DATA_W-1:0] pc_value,
    input logic              branch_taken,
    input logic              disp_valid,
    input logic [DATA_W-1:0] disp_data
);
    a_r2_disp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 6'd0) |=> (disp_valid && disp_data == $past(wr_data)));

    a_r2_disp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == 6'd0) |=> !disp_valid);

    a_r2_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 6'd0) |-> (rd_data == '0));

    a_r5_zero_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 6'd55 || rd_addr == 6'd57) |-> (rd_data == '0));

    a_r10_branch_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 6'd63) |=> (branch_taken && pc_value == $past(wr_data)));

    a_r10_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && wr_addr == 6'd63) && pc_step) |=>
        (!branch_taken && pc_value == $past(pc_value) + DATA_W'(1)));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && wr_addr == 6'd63) && !pc_step) |=> $stable(pc_value));

    a_r10_pc_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 6'd63) |-> (rd_data == pc_value));
endmodule

bind calc_regfile crf_checker #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .rd_addr      (rd_addr),
    .rd_data      (rd_data),
    .pc_step      (pc_step),
    .pc_value     (pc_value),
    .branch_taken (branch_taken),
    .disp_valid   (disp_valid),
    .disp_data    (disp_data)
);

// File: tb/calc_regfile_tb.sv
module calc_regfile_tb;
    localparam time CLK_P = 4ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        pc_step = 1'b0;
    logic [15:0] pc_value;
    logic        branch_taken;
    logic        disp_valid;
    logic [15:0] disp_data;

    int n_vec = 0;
    int n_bad = 0;
    logic [15:0] model [64];

    always #(CLK_P/2) clk = ~clk;

    calc_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pc_step(pc_step), .pc_value(pc_value), .branch_taken(branch_taken),
        .disp_valid(disp_valid), .disp_data(disp_data)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    function automatic string tag_of(input int a);
        if (a == 0) return "R2";
        if (a == 53 || a == 54) return "R4";
        if (a == 55 || a == 57) return "R5";
        if (a == 56) return "R6";
        if (a == 58 || a == 59) return "R7";
        if (a == 61) return "R8";
        if (a == 62) return "R9";
        if (a == 63) return "R10";
        return "R3";
    endfunction

    // Expected read computed from the bench's own copy of written words.
    function automatic logic [15:0] expect_rd(input int a, input logic [15:0] pc);
        logic [16:0] s;
        case (a)
            0, 55, 57: return 16'h0;
            53: return model[54] & ~model[53];
            54: return model[53] & ~model[54];
            56: return (model[56] != 0) ? model[55] : model[57];
            58: return (model[58] >> 1) | (model[58] << 15);
            59: return (model[59] << 1) | (model[59] >> 15);
            61: begin
                s = {1'b0, model[60]} + {1'b0, model[61]};
                return 16'((s % 17'h10000) + (s / 17'h10000));
            end
            62: return model[62] ^ 16'hFFFF;
            63: return pc;
            default: return model[a];
        endcase
    endfunction

    task automatic do_write(input int a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'(a); wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        if (a != 0 && a != 63) model[a] = d;
    endtask

    task automatic read_chk(input int a, input string req, input logic [15:0] exp);
        rd_addr = 6'(a);
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic sweep_all(input logic [15:0] pc);
        for (int a = 0; a < 64; a++) read_chk(a, tag_of(a), expect_rd(a, pc));
    endtask

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog expired got running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int a = 0; a < 64; a++) model[a] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        for (int a = 0; a < 64; a++) read_chk(a, "R1", (a == 62) ? 16'hFFFF : 16'h0);
        chk("R1", {15'b0, disp_valid}, 16'h0);
        chk("R1", {15'b0, branch_taken}, 16'h0);
        chk("R1", pc_value, 16'h0);

        // Sweep: write every storage address with a pattern, then read all.
        for (int r = 0; r < 6; r++) begin
            for (int a = 1; a < 63; a++) begin
                logic [15:0] p;
                p = 16'(a * 40503 + r * 15451 + 7);
                if (a == 56 && (r % 2 == 0)) p = 16'h0;  // R6 false branch
                do_write(a, p);
            end
            sweep_all(pc_value);
        end

        // R8 end-around corner cases
        do_write(60, 16'hFFFF); do_write(61, 16'h0001); read_chk(61, "R8", 16'h0001);
        do_write(60, 16'h8000); do_write(61, 16'h8000); read_chk(61, "R8", 16'h0001);
        do_write(60, 16'h1234); do_write(61, 16'hEDCB); read_chk(61, "R8", 16'hFFFF);
        do_write(60, 16'hFFFF); do_write(61, 16'hFFFF); read_chk(61, "R8", 16'hFFFF);

        // R7 rotation boundary bits
        do_write(58, 16'h0001); read_chk(58, "R7", 16'h8000);
        do_write(59, 16'h8000); read_chk(59, "R7", 16'h0001);

        // R5 / R6: zero-reading words still steer the pick
        do_write(55, 16'hA5A5); do_write(57, 16'h5A5A);
        read_chk(55, "R5", 16'h0); read_chk(57, "R5", 16'h0);
        do_write(56, 16'h0000); read_chk(56, "R6", 16'h5A5A);
        do_write(56, 16'h0100); read_chk(56, "R6", 16'hA5A5);

        // R2 display strobe and no storage
        do_write(0, 16'hBEEF);
        #1;
        chk("R2", {15'b0, disp_valid}, 16'h1);
        chk("R2", disp_data, 16'hBEEF);
        read_chk(0, "R2", 16'h0);
        @(negedge clk); #1;
        chk("R2", {15'b0, disp_valid}, 16'h0);

        // R3 same-cycle read sees old word, new word after edge
        do_write(7, 16'h1111);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'd7; wr_data = 16'h2222; rd_addr = 6'd7;
        #1; chk("R3", rd_data, 16'h1111);
        @(posedge clk); #1;
        chk("R3", rd_data, 16'h2222);
        @(negedge clk); wr_en = 1'b0; model[7] = 16'h2222;

        // R10 stepping
        pc_step = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); pc_step = 1'b0; #1;
        chk("R10", pc_value, 16'd3);
        read_chk(63, "R10", 16'd3);
        // R10 branch write with step in the same cycle: load wins
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'd63; wr_data = 16'hFFFE; pc_step = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; pc_step = 1'b0; #1;
        chk("R10", pc_value, 16'hFFFE);
        chk("R10", {15'b0, branch_taken}, 16'h1);
        @(negedge clk); #1;
        chk("R10", {15'b0, branch_taken}, 16'h0);
        chk("R10", pc_value, 16'hFFFE);
        // R10 wrap
        pc_step = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk); pc_step = 1'b0; #1;
        chk("R10", pc_value, 16'h0000);

        // Final full sweep after all corner writes
        sweep_all(pc_value);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule